// File: doc/BRIEF.md
# Shared-Memory Swizzle Address Mapper

This block turns a linear byte offset inside a destination tile into a permuted offset for a banked on-chip memory with 32 banks. Consumers that walk a tile with a large stride would otherwise hit the same banks over and over. The mapper permutes whole 16-byte chunks within a row. The row index picks the permutation, so consecutive rows put the same logical column into different banks.

A 2-bit mode selects no permutation or a repeat window of 32, 64 or 128 bytes. The caller also gives the inner row length of the tile in bytes. The block raises a warning when that length is longer than the selected window, because the pattern then repeats inside one row and collisions can come back. The block takes one offset per cycle and returns the result one cycle later.

Top module: `swz_addr_map`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0.
- R2: Each cycle with `in_valid` high gives exactly one cycle with `out_valid` high, one clock later. Cycles with `in_valid` low give `out_valid` low.
- R3: Offset bits [3:0] (the byte position inside a 16-byte chunk) are copied to the output unchanged in every mode.
- R4: With `mode` = 0 (no permutation), the output offset equals the input offset.
- R5: With `mode` = 1 (32-byte window), output bit 4 is input bit 4 XOR input bit 7. Bits 5 and 6 are unchanged.
- R6: With `mode` = 2 (64-byte window), output bits [5:4] are input bits [5:4] XOR input bits [8:7]. Bit 6 is unchanged.
- R7: With `mode` = 3 (128-byte window), output bits [6:4] are input bits [6:4] XOR input bits [9:7].
- R8: Offset bits from bit 7 upward are copied to the output unchanged in every mode.
- R9: `out_overrun` is 1 exactly when `mode` is not 0 and `inner_bytes` is strictly greater than the window (32, 64 or 128 bytes for modes 1, 2, 3). A length equal to the window does not raise the flag, and mode 0 never raises it.
- R10: When `in_valid` is low, `out_offset` and `out_overrun` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An input offset is present this cycle |
| in_offset | input | 16 | Linear byte offset inside the tile |
| mode | input | 2 | 0 none, 1 32-byte, 2 64-byte, 3 128-byte window |
| inner_bytes | input | 16 | Inner row length of the tile in bytes |
| out_valid | output | 1 | Result is present |
| out_offset | output | 16 | Permuted byte offset |
| out_overrun | output | 1 | Row length exceeds the selected window |

## Verification
The hardest cases to reach are the ones where one mode's mask decides the result: the row bits must be nonzero exactly at the position that a narrower mode leaves masked. The stimulus therefore sweeps every row index 0 to 7 against every chunk index in all four modes, so each masked-off bit is shown to stay put. The overrun flag is driven at the window length itself and one byte above it in every mode, and back-to-back offsets are followed by idle gaps to show that the output holds its value.

// File: rtl/swz_pkg.sv
package swz_pkg;
  // byte offset -> chunk (atom) granularity
  localparam int ATOM_LOG2 = 4;
  // number of chunk-index bits that can be permuted
  localparam int SEL_W     = 3;

  typedef enum logic [1:0] {
    SWZ_OFF = 2'd0,
    SWZ_W32 = 2'd1,
    SWZ_W64 = 2'd2,
    SWZ_W128 = 2'd3
  } swz_mode_e;
endpackage

// File: rtl/swz_mode_dec.sv
module swz_mode_dec
  import swz_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic [1:0]       mode,
  output logic [SEL_W-1:0] xor_mask,
  output logic [DIM_W-1:0] span_bytes,
  output logic             active
);
  swz_mode_e mode_e;

  always_comb mode_e = swz_mode_e'(mode);

  // mode n enables the n lowest chunk-index bits
  for (genvar i = 0; i < SEL_W; i++) begin : g_mask
    always_comb xor_mask[i] = (int'(mode) > i);
  end

  always_comb begin
    active     = (mode_e != SWZ_OFF);
    span_bytes = DIM_W'(32'd1 << (ATOM_LOG2 + int'(mode)));
  end
endmodule

// File: rtl/swz_permute.sv
module swz_permute
  import swz_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic [OFS_W-1:0] lin_ofs,
  input  logic [SEL_W-1:0] xor_mask,
  output logic [OFS_W-1:0] perm_ofs
);
  localparam int COL_LO = ATOM_LOG2;
  localparam int ROW_LO = ATOM_LOG2 + SEL_W;

  for (genvar b = 0; b < OFS_W; b++) begin : g_bit
    if (b >= COL_LO && b < ROW_LO) begin : g_col
      always_comb perm_ofs[b] = lin_ofs[b] ^ (lin_ofs[b + SEL_W] & xor_mask[b - COL_LO]);
    end else begin : g_pass
      always_comb perm_ofs[b] = lin_ofs[b];
    end
  end
endmodule

// File: rtl/swz_overrun_det.sv
module swz_overrun_det #(
  parameter int DIM_W = 16
) (
  input  logic             active,
  input  logic [DIM_W-1:0] inner_bytes,
  input  logic [DIM_W-1:0] span_bytes,
  output logic             overrun
);
  always_comb overrun = active && (inner_bytes > span_bytes);
endmodule

// File: rtl/swz_addr_map.sv
module swz_addr_map
  import swz_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DIM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OFS_W-1:0] in_offset,
  input  logic [1:0]       mode,
  input  logic [DIM_W-1:0] inner_bytes,
  output logic             out_valid,
  output logic [OFS_W-1:0] out_offset,
  output logic             out_overrun
);
  logic [SEL_W-1:0] xor_mask;
  logic [DIM_W-1:0] span_bytes;
  logic             active;
  logic [OFS_W-1:0] perm_ofs;
  logic             ovr_c;

  logic             vld_q, vld_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             ovr_q, ovr_d;

  swz_mode_dec #(.DIM_W(DIM_W)) u_dec (
    .mode       (mode),
    .xor_mask   (xor_mask),
    .span_bytes (span_bytes),
    .active     (active)
  );

  swz_permute #(.OFS_W(OFS_W)) u_perm (
    .lin_ofs  (in_offset),
    .xor_mask (xor_mask),
    .perm_ofs (perm_ofs)
  );

  swz_overrun_det #(.DIM_W(DIM_W)) u_ovr (
    .active      (active),
    .inner_bytes (inner_bytes),
    .span_bytes  (span_bytes),
    .overrun     (ovr_c)
  );

  // next state: data registers only load on a valid input
  always_comb begin
    vld_d = in_valid;
    ofs_d = ofs_q;
    ovr_d = ovr_q;
    if (in_valid) begin
      ofs_d = perm_ofs;
      ovr_d = ovr_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ofs_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ofs_q <= ofs_d;
      ovr_q <= ovr_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_offset  = ofs_q;
  assign out_overrun = ovr_q;
endmodule

// File: rtl/swz_addr_map_chk.sv
module swz_addr_map_chk #(
  parameter int OFS_W = 16,
  parameter int DIM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OFS_W-1:0] in_offset,
  input logic [1:0]       mode,
  input logic [DIM_W-1:0] inner_bytes,
  input logic             out_valid,
  input logic [OFS_W-1:0] out_offset,
  input logic             out_overrun
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r3_atom_intact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_offset[3:0] == $past(in_offset[3:0]));

  a_r4_off_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=> out_offset == $past(in_offset));

  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_offset[OFS_W-1:7] == $past(in_offset[OFS_W-1:7]));

  a_r9_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0) |=> !out_overrun);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_offset) && $stable(out_overrun)));
endmodule

bind swz_addr_map swz_addr_map_chk #(.OFS_W(OFS_W), .DIM_W(DIM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_offset   (in_offset),
  .mode        (mode),
  .inner_bytes (inner_bytes),
  .out_valid   (out_valid),
  .out_offset  (out_offset),
  .out_overrun (out_overrun)
);

// File: tb/sim_swz_addr_map.sv
module sim_swz_addr_map;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_offset;
  logic [1:0]  mode;
  logic [15:0] inner_bytes;
  logic        out_valid;
  logic [15:0] out_offset;
  logic        out_overrun;

  int checks = 0;
  int errors = 0;
  int pushed = 0;
  int popped = 0;
  bit done = 0;

  typedef struct packed {
    logic [15:0] ofs;
    logic        ovr;
    logic [1:0]  md;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  swz_addr_map u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_offset(in_offset),
    .mode(mode), .inner_bytes(inner_bytes), .out_valid(out_valid),
    .out_offset(out_offset), .out_overrun(out_overrun)
  );

  function automatic exp_t model(logic [15:0] o, logic [1:0] m, logic [15:0] ib);
    exp_t e;
    int span;
    e.ofs = o;
    for (int k = 0; k < int'(m); k++) e.ofs[4+k] = o[4+k] ^ o[7+k];
    span = 16 * (1 << int'(m));
    e.ovr = (m != 2'd0) && (int'(ib) > span);
    e.md  = m;
    return e;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] o, logic [1:0] m, logic [15:0] ib);
    @(negedge clk);
    in_valid = 1'b1; in_offset = o; mode = m; inner_bytes = ib;
    sb.push_back(model(o, m, ib));
    pushed++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_offset = 16'hFFFF; mode = 2'd3; inner_bytes = 16'hFFFF;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R2 unexpected output", 1, 0);
      end else begin
        exp_t e;
        string tg;
        e = sb.pop_front();
        popped++;
        case (e.md)
          2'd0: tg = "R4";
          2'd1: tg = "R5";
          2'd2: tg = "R6";
          default: tg = "R7";
        endcase
        check(out_offset[3:0] == e.ofs[3:0], "R3 low bits", out_offset[3:0], e.ofs[3:0]);
        check(out_offset[6:4] == e.ofs[6:4], tg, out_offset, e.ofs);
        check(out_offset[15:7] == e.ofs[15:7], "R8 upper bits", out_offset, e.ofs);
        check(out_overrun == e.ovr, "R9 overrun", out_overrun, e.ovr);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", pushed, popped);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] last;
    rst_n = 1'b0; in_valid = 1'b0; in_offset = '0; mode = '0; inner_bytes = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

    // sweep rows x chunks x modes, distinct byte and high bits
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          drive(16'((m * 16 + r + c) << 10) | 16'(r << 7) | 16'(c << 4) | 16'((r ^ c) & 15),
                2'(m), 16'd16);

    // overrun boundaries: equal to window and one above
    for (int m = 0; m < 4; m++) begin
      drive(16'h0123, 2'(m), 16'(16 << m));
      drive(16'h0ABC, 2'(m), 16'((16 << m) + 1));
    end
    drive(16'h0F00, 2'd0, 16'hFFFF);

    // R10 hold across idle gap
    drive(16'h3C95, 2'd3, 16'd512);
    idle(1);
    @(negedge clk);
    last = out_offset;
    check(out_valid == 1'b0, "R2 idle gives no valid", out_valid, 0);
    idle(4);
    check(out_offset == last, "R10 offset held", out_offset, last);
    check(out_overrun == 1'b1, "R10 flag held", out_overrun, 1);

    idle(3);
    check(sb.size() == 0 && pushed == popped, "R2 one output per input", popped, pushed);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule